// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache Controller

This block is a single-level, direct-mapped data cache placed between a CPU request port and a slower main-memory port. Each CPU byte address is split into a tag, a line index and an offset. Every line holds a valid flag, a dirty flag, a stored tag and a block of words. Every request is checked against the tag of the line its index selects. Read hits return data without any memory traffic. A miss brings the whole line in from memory as a burst of word beats. If the line being replaced has been modified, it is first written out as a burst.

Writes are byte-granular. A write changes only the byte lanes its enable mask selects, and only after the tag check has confirmed the line is present. A write hit sets the line's dirty flag and does not touch memory. A write miss allocates the line with a fill and then applies the write exactly as a hit would. A clean victim is discarded without any memory write.

The controller runs the states IDLE, COMPARE, WRITEBACK, FILL and RESPOND. The transitions are:
- IDLE→COMPARE when a request is presented; the request is captured at this point.
- COMPARE→IDLE on a hit.
- COMPARE→WRITEBACK on a miss whose victim is valid and dirty.
- COMPARE→FILL on a miss whose victim is clean or invalid.
- WRITEBACK→FILL after the last write-back beat.
- FILL→RESPOND after the last fill beat.
- RESPOND→IDLE always.

Top module: `wb_cache_ctrl`

## Requirements
- R1: After a synchronous reset, `cpu_ready` and `mem_req` are low and every line is invalid, so the first access to any address misses, even when its tag field is zero.
- R2: With the default parameters, address bits [1:0] select the byte, [3:2] the word within a 16-byte line, [6:4] the line index and [15:7] the tag. Two addresses that differ only in bits [3:2] share a line; two with equal index and different tags evict each other.
- R3: A read hit raises `cpu_ready` in the COMPARE cycle, the first cycle after the request is captured. It returns the latest data for that word and makes no memory request.
- R4: A read miss fills the line with 4 read beats at ascending word addresses from the line base (base, base+4, base+8, base+12). It then answers in RESPOND with the requested word.
- R5: A write hit changes only the byte lanes whose `cpu_be` bit is set (bit k covers data bits 8k+7..8k). It makes no memory access and marks the line dirty.
- R6: A write miss first fills the line from memory and then merges the enabled bytes into it, leaving the line dirty.
- R7: A miss whose victim is dirty writes 4 beats of the victim's current data to the victim's own line addresses, in ascending order. All of these beats complete before the first fill beat.
- R8: A miss whose victim is clean or invalid makes no memory write.
- R9: `cpu_ready` is high only in COMPARE on a hit or in RESPOND, and never in the same cycle as `mem_req`. The CPU holds its request until `cpu_ready`.
- R10: A memory beat completes only in a cycle with `mem_ack` high. While `mem_req` is high and `mem_ack` low, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_valid | input | 1 | CPU request present, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte-lane write enables |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` on a read |
| mem_req | output | 1 | Memory burst beat requested |
| mem_we | output | 1 | 1 = write-back beat, 0 = fill beat |
| mem_addr | output | 16 | Byte address of the current beat |
| mem_wdata | output | 32 | Write-back beat data |
| mem_ack | input | 1 | Current beat completes this cycle |
| mem_rdata | input | 32 | Fill beat data, valid with `mem_ack` |

## Verification
A lost or stray dirty flag shows up at the next conflicting miss. The bench then sees a missing or extra write-back burst in the cycles before the fill, or reads stale bytes back once the line returns from memory. A wrong valid flag or tag shows at once as a wrong hit or miss: a one-cycle answer where a fill was due, or a burst where none was. A byte-lane error shows on the next read of that word. The bench tracks the expected occupancy and contents of every line and compares each memory beat's address and data, and each response, as it happens.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_COMPARE,
        S_WRITEBACK,
        S_FILL,
        S_RESPOND
    } ctl_state_t;

endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
    parameter int LINES = 8,
    parameter int IDX_W = 3,
    parameter int TAG_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] look_tag,
    input  logic             install,
    input  logic             mark_dirty,
    output logic             line_valid,
    output logic             line_dirty,
    output logic [TAG_W-1:0] line_tag,
    output logic             hit
);

    logic [LINES-1:0] vld_q;
    logic [LINES-1:0] drt_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            drt_q <= '0;
        end else begin
            if (install) begin
                vld_q[idx] <= 1'b1;
                drt_q[idx] <= 1'b0;
                tag_q[idx] <= look_tag;
            end
            if (mark_dirty) begin
                drt_q[idx] <= 1'b1;
            end
        end
    end

    always_comb begin
        line_valid = vld_q[idx];
        line_dirty = drt_q[idx];
        line_tag   = tag_q[idx];
        hit        = line_valid && (line_tag == look_tag);
    end

    // R5: only a present line may be marked modified
    p_dirty_on_valid_r5: assert property (@(posedge clk) disable iff (rst)
        mark_dirty |-> line_valid);

endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store #(
    parameter int LINES      = 8,
    parameter int LINE_WORDS = 4,
    parameter int WORD_W     = 32,
    parameter int IDX_W      = 3,
    parameter int BEAT_W     = 2
) (
    input  logic                  clk,
    input  logic [IDX_W-1:0]      idx,
    input  logic [BEAT_W-1:0]     word,
    input  logic                  wr_en,
    input  logic [WORD_W/8-1:0]   wr_be,
    input  logic [WORD_W-1:0]     wr_data,
    output logic [WORD_W-1:0]     rd_data
);

    localparam int DEPTH = LINES * LINE_WORDS;
    localparam int LANES = WORD_W / 8;

    logic [WORD_W-1:0]        words_q [DEPTH];
    logic [IDX_W+BEAT_W-1:0]  slot;

    assign slot    = {idx, word};
    assign rd_data = words_q[slot];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < LANES; b++) begin
                if (wr_be[b]) begin
                    words_q[slot][b*8 +: 8] <= wr_data[b*8 +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/wbc_fsm.sv
module wbc_fsm
    import wbc_pkg::*;
#(
    parameter int LINE_WORDS = 4,
    parameter int BEAT_W     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              req_we,
    input  logic              hit,
    input  logic              victim_dirty,
    input  logic              mem_ack,
    output ctl_state_t        state,
    output logic [BEAT_W-1:0] beat,
    output logic              capture,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic              fill_wr,
    output logic              cpu_wr,
    output logic              install,
    output logic              mark_dirty
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(LINE_WORDS - 1);

    ctl_state_t        nxt;
    logic [BEAT_W-1:0] beat_nxt;
    logic              beat_last;

    assign beat_last = (beat == LAST_BEAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            beat  <= '0;
        end else begin
            state <= nxt;
            beat  <= beat_nxt;
        end
    end

    always_comb begin
        nxt      = state;
        beat_nxt = beat;
        unique case (state)
            S_IDLE: begin
                if (cpu_valid) nxt = S_COMPARE;
            end
            S_COMPARE: begin
                beat_nxt = '0;
                if (hit)               nxt = S_IDLE;
                else if (victim_dirty) nxt = S_WRITEBACK;
                else                   nxt = S_FILL;
            end
            S_WRITEBACK: begin
                if (mem_ack) begin
                    beat_nxt = beat_last ? '0 : beat + BEAT_W'(1);
                    if (beat_last) nxt = S_FILL;
                end
            end
            S_FILL: begin
                if (mem_ack) begin
                    beat_nxt = beat_last ? '0 : beat + BEAT_W'(1);
                    if (beat_last) nxt = S_RESPOND;
                end
            end
            S_RESPOND: begin
                nxt = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        capture    = 1'b0;
        cpu_ready  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        fill_wr    = 1'b0;
        cpu_wr     = 1'b0;
        install    = 1'b0;
        mark_dirty = 1'b0;
        unique case (state)
            S_IDLE: begin
                capture = cpu_valid;
            end
            S_COMPARE: begin
                cpu_ready  = hit;
                cpu_wr     = hit && req_we;
                mark_dirty = hit && req_we;
            end
            S_WRITEBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            S_FILL: begin
                mem_req = 1'b1;
                fill_wr = mem_ack;
                install = mem_ack && beat_last;
            end
            S_RESPOND: begin
                cpu_ready  = 1'b1;
                cpu_wr     = req_we;
                mark_dirty = req_we;
            end
            default: ;
        endcase
    end

    // R9: a response never overlaps a memory beat
    p_ready_no_mem_r9: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> !mem_req);

    // R7: the fill follows the write-back's last beat directly
    p_wb_then_fill_r7: assert property (@(posedge clk) disable iff (rst)
        (state == S_WRITEBACK && mem_ack && beat == LAST_BEAT) |=> (state == S_FILL));

    // R8: a clean miss goes straight to the fill
    p_clean_skip_r8: assert property (@(posedge clk) disable iff (rst)
        (state == S_COMPARE && !hit && !victim_dirty) |=> (state == S_FILL));

endmodule

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl
    import wbc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int LINES      = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cpu_valid,
    input  logic                cpu_we,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [WORD_W-1:0]   cpu_wdata,
    input  logic [WORD_W/8-1:0] cpu_be,
    output logic                cpu_ready,
    output logic [WORD_W-1:0]   cpu_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic                mem_ack,
    input  logic [WORD_W-1:0]   mem_rdata
);

    localparam int LANES  = WORD_W / 8;
    localparam int BOFF_W = $clog2(LANES);
    localparam int BEAT_W = $clog2(LINE_WORDS);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - BOFF_W - BEAT_W - IDX_W;

    // captured request
    logic              rq_we;
    logic [ADDR_W-1:0] rq_addr;
    logic [WORD_W-1:0] rq_wdata;
    logic [LANES-1:0]  rq_be;

    logic [TAG_W-1:0]  rq_tag;
    logic [IDX_W-1:0]  rq_idx;
    logic [BEAT_W-1:0] rq_word;

    assign rq_tag  = rq_addr[ADDR_W-1 -: TAG_W];
    assign rq_idx  = rq_addr[BOFF_W+BEAT_W +: IDX_W];
    assign rq_word = rq_addr[BOFF_W +: BEAT_W];

    ctl_state_t        state;
    logic [BEAT_W-1:0] beat;
    logic capture, fill_wr, cpu_wr, install, mark_dirty;
    logic line_valid, line_dirty, hit, victim_dirty;
    logic [TAG_W-1:0]  line_tag;

    logic              ds_we;
    logic [BEAT_W-1:0] ds_word;
    logic [LANES-1:0]  ds_be;
    logic [WORD_W-1:0] ds_wdata;
    logic [WORD_W-1:0] ds_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            rq_we    <= 1'b0;
            rq_addr  <= '0;
            rq_wdata <= '0;
            rq_be    <= '0;
        end else if (capture) begin
            rq_we    <= cpu_we;
            rq_addr  <= cpu_addr;
            rq_wdata <= cpu_wdata;
            rq_be    <= cpu_be;
        end
    end

    assign victim_dirty = line_valid && line_dirty;

    wbc_fsm #(
        .LINE_WORDS (LINE_WORDS),
        .BEAT_W     (BEAT_W)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .cpu_valid    (cpu_valid),
        .req_we       (rq_we),
        .hit          (hit),
        .victim_dirty (victim_dirty),
        .mem_ack      (mem_ack),
        .state        (state),
        .beat         (beat),
        .capture      (capture),
        .cpu_ready    (cpu_ready),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .fill_wr      (fill_wr),
        .cpu_wr       (cpu_wr),
        .install      (install),
        .mark_dirty   (mark_dirty)
    );

    wbc_tag_store #(
        .LINES (LINES),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk        (clk),
        .rst        (rst),
        .idx        (rq_idx),
        .look_tag   (rq_tag),
        .install    (install),
        .mark_dirty (mark_dirty),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .line_tag   (line_tag),
        .hit        (hit)
    );

    always_comb begin
        ds_we    = fill_wr || cpu_wr;
        ds_word  = (state == S_WRITEBACK || state == S_FILL) ? beat : rq_word;
        ds_be    = fill_wr ? {LANES{1'b1}} : rq_be;
        ds_wdata = fill_wr ? mem_rdata : rq_wdata;
    end

    wbc_data_store #(
        .LINES      (LINES),
        .LINE_WORDS (LINE_WORDS),
        .WORD_W     (WORD_W),
        .IDX_W      (IDX_W),
        .BEAT_W     (BEAT_W)
    ) u_data (
        .clk     (clk),
        .idx     (rq_idx),
        .word    (ds_word),
        .wr_en   (ds_we),
        .wr_be   (ds_be),
        .wr_data (ds_wdata),
        .rd_data (ds_rdata)
    );

    always_comb begin
        cpu_rdata = ds_rdata;
        mem_wdata = ds_rdata;
        if (state == S_WRITEBACK)
            mem_addr = {line_tag, rq_idx, beat, {BOFF_W{1'b0}}};
        else
            mem_addr = {rq_tag, rq_idx, beat, {BOFF_W{1'b0}}};
    end

    // R10: an unacknowledged beat holds its address, direction and data
    p_beat_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R3: a hit in COMPARE answers at once and stays off the memory port
    p_hit_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (state == S_COMPARE && hit) |-> (cpu_ready && !mem_req));

    // R4: after the fill the requested line is present
    p_respond_present_r4: assert property (@(posedge clk) disable iff (rst)
        (state == S_RESPOND) |-> hit);

    // R5: a write hit leaves the line dirty
    p_write_dirty_r5: assert property (@(posedge clk) disable iff (rst)
        (state == S_COMPARE && hit && rq_we) |=> victim_dirty);

    // R6: an allocating write leaves the line dirty
    p_alloc_dirty_r6: assert property (@(posedge clk) disable iff (rst)
        (state == S_RESPOND && rq_we) |=> victim_dirty);

endmodule

// File: tb/sim_wb_cache_ctrl.sv
`timescale 1ns/1ps
module sim_wb_cache_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_valid = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    wb_cache_ctrl u0 (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] bmem   [int];
    logic [31:0] shadow [int];

    bit        occ_valid [8];
    bit        occ_dirty [8];
    int        occ_tag   [8];

    int wb_beats, fill_beats, exp_wb;
    int wb_base, fill_base;
    bit prev_wait = 1'b0;
    logic [15:0] prev_addr = '0;
    bit ack_gap = 1'b0;

    function automatic logic [31:0] init_word(int wa);
        return {16'hC0DE ^ wa[15:0], wa[15:0] ^ 16'h3A5C};
    endfunction

    function automatic logic [31:0] mem_rd(int wa);
        if (bmem.exists(wa)) return bmem[wa];
        return init_word(wa);
    endfunction

    function automatic logic [31:0] shadow_rd(int wa);
        if (shadow.exists(wa)) return shadow[wa];
        return init_word(wa);
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // memory model: one beat acknowledged every other cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_wait && mem_req)
                chk(mem_addr == prev_addr, "R10", "address held while waiting", {16'h0, mem_addr}, {16'h0, prev_addr});
            chk(!(cpu_ready && mem_req), "R9", "ready overlaps memory beat", {31'h0, mem_req}, 32'h0);
        end
        if (!rst && mem_req && !ack_gap) begin
            mem_ack = 1'b1;
            ack_gap = 1'b1;
            if (mem_we) begin
                chk(fill_beats == 0, "R7", "write-back beat after fill began", fill_beats, 0);
                chk(wb_beats < exp_wb, "R8", "unexpected write-back beat", wb_beats, exp_wb);
                chk(int'(mem_addr) == wb_base + 4*wb_beats, "R7", "write-back address",
                    {16'h0, mem_addr}, wb_base + 4*wb_beats);
                chk(mem_wdata == shadow_rd(int'(mem_addr) >> 2), "R7", "write-back data",
                    mem_wdata, shadow_rd(int'(mem_addr) >> 2));
                bmem[int'(mem_addr) >> 2] = mem_wdata;
                wb_beats++;
            end else begin
                chk(wb_beats == exp_wb, "R7", "fill began before write-back ended", wb_beats, exp_wb);
                chk(int'(mem_addr) == fill_base + 4*fill_beats, "R4", "fill address",
                    {16'h0, mem_addr}, fill_base + 4*fill_beats);
                mem_rdata = mem_rd(int'(mem_addr) >> 2);
                fill_beats++;
            end
        end else begin
            mem_ack = 1'b0;
            ack_gap = 1'b0;
        end
        prev_wait = mem_req && !mem_ack;
        prev_addr = mem_addr;
    end

    task automatic access(input bit we, input logic [15:0] a, input logic [31:0] wd,
                          input logic [3:0] be, input string rq);
        int idx, tag, wa, lat;
        bit hit;
        logic [31:0] got, exp, cur;
        idx = int'(a[6:4]);
        tag = int'(a[15:7]);
        wa  = int'(a) >> 2;
        hit = occ_valid[idx] && occ_tag[idx] == tag;
        exp_wb     = (!hit && occ_valid[idx] && occ_dirty[idx]) ? 4 : 0;
        wb_base    = (occ_tag[idx] << 7) | (idx << 4);
        fill_base  = (tag << 7) | (idx << 4);
        wb_beats   = 0;
        fill_beats = 0;
        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!cpu_ready && lat < 200);
        got = cpu_rdata;
        cpu_valid = 1'b0;
        chk(cpu_ready, rq, "request never completed", lat, 0);
        if (hit) chk(lat == 1, "R3", "hit latency", lat, 1);
        else     chk(lat > 1, "R1", "miss answered like a hit", lat, 2);
        chk(fill_beats == (hit ? 0 : 4), hit ? "R3" : "R4", "fill beat count", fill_beats, hit ? 0 : 4);
        chk(wb_beats == exp_wb, exp_wb != 0 ? "R7" : "R8", "write-back beat count", wb_beats, exp_wb);
        if (!we) begin
            exp = shadow_rd(wa);
            chk(got == exp, rq, "read data", got, exp);
        end else begin
            cur = shadow_rd(wa);
            for (int b = 0; b < 4; b++)
                if (be[b]) cur[b*8 +: 8] = wd[b*8 +: 8];
            shadow[wa] = cur;
        end
        if (!hit) begin
            occ_valid[idx] = 1'b1;
            occ_tag[idx]   = tag;
            occ_dirty[idx] = 1'b0;
        end
        if (we) occ_dirty[idx] = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            occ_valid[i] = 1'b0; occ_dirty[i] = 1'b0; occ_tag[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!cpu_ready, "R1", "ready after reset", {31'h0, cpu_ready}, 0);
        chk(!mem_req, "R1", "mem_req after reset", {31'h0, mem_req}, 0);

        // R1/R4: tag zero on an invalid line must still miss
        access(1'b0, 16'h0000, 32'h0, 4'h0, "R4");
        // R2/R3: another word of the same line hits
        access(1'b0, 16'h0004, 32'h0, 4'h0, "R2");
        // R5: partial write hit, then read back merged word
        access(1'b1, 16'h0008, 32'hAABBCCDD, 4'b0101, "R5");
        access(1'b0, 16'h0008, 32'h0, 4'h0, "R5");
        // R2/R7: same index, new tag, dirty victim written back
        access(1'b0, 16'h0080, 32'h0, 4'h0, "R7");
        // R8/R7: clean victim, old merged data returns from memory
        access(1'b0, 16'h0008, 32'h0, 4'h0, "R7");
        // R6: write miss allocates then merges one byte
        access(1'b1, 16'h0110, 32'h5A000000, 4'b1000, "R6");
        access(1'b0, 16'h0110, 32'h0, 4'h0, "R6");
        access(1'b1, 16'h0114, 32'h01234567, 4'b1111, "R5");
        // R7: dirty line with two modified words evicted
        access(1'b0, 16'h0190, 32'h0, 4'h0, "R7");
        access(1'b0, 16'h0114, 32'h0, 4'h0, "R7");
        // sweep over all lines
        for (int i = 0; i < 8; i++)
            access(1'b1, 16'((5 << 7) | (i << 4) | ((i % 4) << 2)), 32'hF00D0000 + i, 4'((i % 15) + 1), "R5");
        for (int i = 0; i < 8; i++)
            access(1'b0, 16'((6 << 7) | (i << 4)), 32'h0, 4'h0, "R7");
        for (int i = 0; i < 8; i++)
            access(1'b0, 16'((5 << 7) | (i << 4) | ((i % 4) << 2)), 32'h0, 4'h0, "R6");
        for (int i = 0; i < 8; i++)
            access(1'b0, 16'((5 << 7) | (i << 4) | (((i + 1) % 4) << 2)), 32'h0, 4'h0, "R3");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule